// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Converter

This block derives a slow coprocessor clock-enable from a fast master clock using an exact rational ratio rather than an integer divider. The ratio is the coprocessor's cycle rate over the master clock rate. It is built from the master-clocks-per-scanline, scanlines-per-frame and frames-per-second figures of the selected video timing. One mode input selects between a 60 Hz and a 50 Hz timing set. With the default parameters the numerator is 1025280 in both modes. The denominators are 21442080 at 60 Hz and 21278400 at 50 Hz, so roughly one master cycle in 21 carries an enable.

A running accumulator adds the numerator on every master cycle. When the sum reaches the selected denominator, the block emits a one-cycle enable and subtracts the denominator. Over time this spreads the enables evenly and without drift. Each enable advances a free-running coprocessor cycle count. On every 32nd enable the block also emits a tick for a downstream signal-processing unit. Logic elsewhere on the chip uses the enable and the tick as clock qualifiers.

Top module: `rate_conv`

## Requirements
- R1: While reset is high at a rising edge, the enable, the tick and the cycle count all read 0 after that edge, and the accumulator returns to 0.
- R2: With the mode input at 0 (60 Hz), each edge adds 1025280 to the accumulator. If the sum is at least 21442080, the enable is high for the following cycle and 21442080 is subtracted. From reset, the first enable appears after the 21st edge.
- R3: With the mode input at 1 (50 Hz), the same rule applies with denominator 21278400. From reset, the first enable appears after the 21st edge.
- R4: The enable is never high in two consecutive cycles, and two enables are at least 20 edges apart.
- R5: The cycle count increases by exactly one at the edge that ends each enable cycle, and holds otherwise. It wraps modulo 2^CNT_W.
- R6: The tick is high exactly in those enable cycles in which the low five bits of the cycle count (before the increment) are zero. It is never high without the enable.
- R7: A change of the mode input applies to the very next edge, and the accumulator keeps its value across the change.
- R8: After N edges since reset in a fixed mode, the cycle count equals floor((N-1)*1025280/den) modulo 2^CNT_W, where den is the denominator of that mode. The rate therefore does not drift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| palMode | input | 1 | Ratio select: 0 = 60 Hz timing, 1 = 50 Hz timing |
| cpuEn | output | 1 | Coprocessor clock-enable, one master cycle wide |
| dspTick | output | 1 | Enable divided by 32 for the signal-processing unit |
| cpuCycles | output | CNT_W | Free-running coprocessor cycle count |

## Verification
The enable is registered, so it reflects the accumulator sum of the edge before it. The count and tick lag that by nothing more: the count moves at the edge that closes an enable cycle, and the tick is combinational from the enable and the current count. The bench changes inputs at a falling edge and updates its arithmetic model for the coming rising edge. It compares all three outputs at the next falling edge, so every comparison lands exactly one edge after the stimulus it depends on. The long-run checks count edges since reset and compare the count with the closed-form floor expression, using a narrow count width so that wrap-around is covered.

// File: rtl/rate_conv_pkg.sv
package rate_conv_pkg;

  // Strobes passed from the ratio control to the counting datapath
  typedef struct packed {
    logic advance;
  } convStrobe_t;

  typedef enum logic {
    TIMING_60 = 1'b0,
    TIMING_50 = 1'b1
  } timingSel_t;

  // Numerator: coprocessor cycles per second scaled by its multiplier
  function automatic longint calcNum(input longint cpuRate, input longint mult);
    return cpuRate * mult;
  endfunction

  // Denominator: master clocks per second for a timing set
  function automatic longint calcDen(input longint perLine, input longint lines,
                                     input longint fps);
    return perLine * lines * fps;
  endfunction

  function automatic longint maxOf(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rate_conv_ctrl.sv
module rate_conv_ctrl
  import rate_conv_pkg::*;
#(
  parameter longint NUM   = 1025280,
  parameter longint DEN_A = 21442080,
  parameter longint DEN_B = 21278400,
  parameter int     ACC_W = 26
) (
  input  logic        clk,
  input  logic        rst,
  input  timingSel_t  timingSel,
  output convStrobe_t strobe
);

  localparam logic [ACC_W-1:0] NUM_V   = ACC_W'(NUM);
  localparam logic [ACC_W-1:0] DEN_A_V = ACC_W'(DEN_A);
  localparam logic [ACC_W-1:0] DEN_B_V = ACC_W'(DEN_B);

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] sumNext;
  logic [ACC_W-1:0] denSel;
  logic [ACC_W-1:0] accNext;
  logic             hit;
  logic             enQ;

  // Mode is looked at every edge; no history of the previous mode is kept
  always_comb begin
    unique case (timingSel)
      TIMING_50: denSel = DEN_B_V;
      default:   denSel = DEN_A_V;
    endcase
  end

  always_comb begin
    sumNext = accQ + NUM_V;
    hit     = (sumNext >= denSel);
    accNext = hit ? (sumNext - denSel) : sumNext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
      enQ  <= 1'b0;
    end else begin
      accQ <= accNext;
      enQ  <= hit;
    end
  end

  assign strobe.advance = enQ;

endmodule

// File: rtl/rate_conv_dp.sv
module rate_conv_dp
  import rate_conv_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DSP_DIV = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  convStrobe_t      strobe,
  output logic [CNT_W-1:0] cycleCnt,
  output logic             divTick
);

  localparam int DIV_W = $clog2(DSP_DIV);

  logic [CNT_W-1:0] cntQ;
  logic             lowZero;

  generate
    if (DIV_W == 0) begin : g_nodiv
      assign lowZero = 1'b1;
    end else begin : g_div
      assign lowZero = (cntQ[DIV_W-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (strobe.advance) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  assign divTick  = strobe.advance & lowZero;
  assign cycleCnt = cntQ;

endmodule

// File: rtl/rate_conv.sv
module rate_conv
  import rate_conv_pkg::*;
#(
  parameter longint CPU_RATE   = 32040,
  parameter longint CPU_MULT   = 32,
  parameter longint CLK_PER_LN = 1364,
  parameter longint LINES_60   = 262,
  parameter longint LINES_50   = 312,
  parameter longint FPS_60     = 60,
  parameter longint FPS_50     = 50,
  parameter int     CNT_W      = 32,
  parameter int     DSP_DIV    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             palMode,
  output logic             cpuEn,
  output logic             dspTick,
  output logic [CNT_W-1:0] cpuCycles
);

  localparam longint NUM   = calcNum(CPU_RATE, CPU_MULT);
  localparam longint DEN60 = calcDen(CLK_PER_LN, LINES_60, FPS_60);
  localparam longint DEN50 = calcDen(CLK_PER_LN, LINES_50, FPS_50);
  localparam int     ACC_W = $clog2(maxOf(DEN60, DEN50) + NUM) + 1;

  convStrobe_t strobe;
  timingSel_t  timingSel;

  assign timingSel = palMode ? TIMING_50 : TIMING_60;

  rate_conv_ctrl #(
    .NUM  (NUM),
    .DEN_A(DEN60),
    .DEN_B(DEN50),
    .ACC_W(ACC_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .timingSel(timingSel),
    .strobe   (strobe)
  );

  rate_conv_dp #(
    .CNT_W  (CNT_W),
    .DSP_DIV(DSP_DIV)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cycleCnt(cpuCycles),
    .divTick (dspTick)
  );

  assign cpuEn = strobe.advance;

endmodule

// File: rtl/rate_conv_chk.sv
module rate_conv_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             palMode,
  input logic             cpuEn,
  input logic             dspTick,
  input logic [CNT_W-1:0] cpuCycles
);

  logic [7:0] gapCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= '0;
    end else if (cpuEn) begin
      gapCnt <= '0;
    end else if (gapCnt != 8'hff) begin
      gapCnt <= gapCnt + 8'd1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cpuCycles == '0) && !cpuEn && !dspTick);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpuEn |=> !cpuEn);

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cpuEn |-> (gapCnt >= 8'd19));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpuCycles == $past(cpuCycles) + CNT_W'($past(cpuEn))));

  // R6
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    dspTick |-> cpuEn);

endmodule

bind rate_conv rate_conv_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .palMode  (palMode),
  .cpuEn    (cpuEn),
  .dspTick  (dspTick),
  .cpuCycles(cpuCycles)
);

// File: tb/rate_conv_tb_top.sv
`timescale 1ns/1ps
module rate_conv_tb_top;

  localparam int     CW    = 9;
  localparam longint NUM   = 64'd32040 * 64'd32;
  localparam longint D60   = 64'd1364 * 64'd262 * 64'd60;
  localparam longint D50   = 64'd1364 * 64'd312 * 64'd50;
  localparam longint CMASK = (64'd1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          palMode = 1'b0;
  logic          cpuEn;
  logic          dspTick;
  logic [CW-1:0] cpuCycles;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint mAcc = 0;
  bit     mEn = 1'b0;
  longint mCnt = 0;
  bit     prevEn = 1'b0;

  always #4 clk = ~clk;

  rate_conv #(.CNT_W(CW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .palMode  (palMode),
    .cpuEn    (cpuEn),
    .dspTick  (dspTick),
    .cpuCycles(cpuCycles)
  );

  function automatic longint expCount(input longint n, input longint den);
    if (n < 1) return 0;
    return ((n - 1) * NUM / den) & CMASK;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called just after a falling edge: apply inputs, model the coming rising edge,
  // then compare at the following falling edge.
  task automatic step(input bit r, input bit m, input string tag);
    longint sum;
    longint den;
    rst = r;
    palMode = m;
    if (r) begin
      mAcc = 0; mEn = 1'b0; mCnt = 0;
    end else begin
      mCnt = (mCnt + longint'(mEn)) & CMASK;
      sum = mAcc + NUM;
      den = m ? D50 : D60;
      if (sum >= den) begin mAcc = sum - den; mEn = 1'b1; end
      else begin mAcc = sum; mEn = 1'b0; end
    end
    @(negedge clk);
    chk(tag, longint'(cpuEn), longint'(mEn));
    chk("R5", longint'(cpuCycles), mCnt);
    chk("R6", longint'(dspTick), longint'(mEn && ((mCnt % 32) == 0)));
    if (!r) chk("R4", longint'(cpuEn && prevEn), 0);
    prevEn = cpuEn;
  endtask

  task automatic firstPulse(input bit m, input string tag);
    int edges;
    repeat (3) step(1'b1, m, "R1");
    chk("R1", longint'(cpuCycles), 0);
    edges = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, m, tag);
      edges++;
      if (cpuEn) break;
    end
    chk(tag, edges, 21);
  endtask

  task automatic longRun(input bit m, input int n, input string tag);
    repeat (2) step(1'b1, m, "R1");
    for (int i = 0; i < n; i++) step(1'b0, m, tag);
    chk("R8", longint'(cpuCycles), expCount(n, m ? D50 : D60));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (4) step(1'b1, 1'b0, "R1");
    chk("R1", longint'(cpuEn), 0);
    chk("R1", longint'(dspTick), 0);
    chk("R1", longint'(cpuCycles), 0);

    firstPulse(1'b0, "R2");
    firstPulse(1'b1, "R3");

    longRun(1'b0, 20000, "R2");
    longRun(1'b1, 20000, "R3");

    // R7: random mode changes with the accumulator carried across, rare resets (R1)
    repeat (2) step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 15000; i++) begin
      bit m;
      bit r;
      m = ($urandom % 4) == 0 ? ~palMode : palMode;
      r = ($urandom % 3000) == 0;
      step(r, m, r ? "R1" : "R7");
    end

    // R7 directed: switch mode right before the enable would fire
    repeat (2) step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b1, "R7");
    for (int i = 0; i < 100; i++) step(1'b0, i[0], "R7");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule